// File: doc/BRIEF.md
# Sync-Word-Gated Receive Bit FIFO

This block sits on the receive side of a packet radio data path, just after the demodulator. It takes a serial bit stream that comes with a one-cycle valid strobe for each bit. It stores received bits in a small FIFO for a host to read out one bit at a time. In its default mode, nothing is stored until a fixed 16-bit synchronization word has appeared in the stream. In continuous mode, every strobed bit is stored, whether it is noise or data.

The host programs the block with a 16-bit command word. A write is accepted only when the upper byte of the word is the expected command code. The lower byte holds four settings:
- a bit-count threshold for the fill interrupt;
- the start-condition select;
- a fill-enable bit;
- one bit that is stored for a neighbouring supply-glitch function.

Clearing the fill-enable bit flushes the FIFO and re-arms the sync search. A sticky overrun flag records that bits arrived while the FIFO was full.

Top module: `sync_bit_fifo`

## Requirements
- R1: After reset, the settings are: threshold 8, sync-gated start, fill disabled and glitch bit 0 (command value CA80h). The FIFO is empty, and `fill_irq` and `overrun` are low.
- R2: A command word is accepted only when `cfg_data[15:8]` equals CAh. Any other value has no effect. Bit 3 of the command word is spare and is always written as 0.
- R3: `cfg_data[7:4]` sets the threshold. `fill_irq` is high exactly while the stored bit count is nonzero and at least the threshold.
- R4: When `cfg_data[2]` is 1 (continuous mode) and fill is enabled, every strobed bit is stored.
- R5: When `cfg_data[2]` is 0 and fill is enabled, nothing is stored until the last 16 strobed bits, oldest first, equal 2DD4h. The bits of that word are not stored. Storing starts with the next strobed bit.
- R6: `cfg_data[1]` is the fill enable. An accepted write with this bit at 0 empties the FIFO, clears `overrun` and re-arms the sync search. While fill is disabled, no bit is stored.
- R7: Once the sync word has been found, later bits are all stored, including further copies of 2DD4h, until fill is disabled.
- R8: The FIFO holds 16 bits. `rd_data` shows the oldest stored bit whenever `fifo_empty` is low. A pulse on `rd_en` removes that bit. `fill_level` gives the stored count.
- R9: A bit that arrives while the FIFO is full and nothing is read in the same cycle is dropped, and `overrun` is set. `overrun` stays set until a flush.
- R10: `cfg_data[0]` is stored from each accepted write and driven on `rst_guard_off`. It has no other effect.
- R11: A read and a stored bit in the same cycle on a full FIFO keep the level at 16 and do not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Command word strobe |
| cfg_data | input | 16 | Command word: code in the upper byte, settings in the lower byte |
| bit_valid | input | 1 | Strobe for one received bit |
| bit_in | input | 1 | Received bit |
| rd_en | input | 1 | Pops the oldest stored bit |
| rd_data | output | 1 | Oldest stored bit |
| fifo_empty | output | 1 | No bits are stored |
| fill_level | output | 5 | Number of stored bits |
| fill_irq | output | 1 | Fill interrupt level |
| overrun | output | 1 | Sticky data-loss flag |
| rst_guard_off | output | 1 | Stored glitch-reset disable bit |

## Verification
The assertions assume that the host never sets spare bit 3 in an accepted command word. They also assume that a read pulse either meets a nonempty FIFO or is simply ignored. The bench holds all command traffic to that rule, including the random phase, where it masks bit 3 to zero. In the random phase it mixes wrong command codes, bit strobes, reads and toggles of the enable bit. Directed passages place the sync word at exact positions: once after noise, and again inside already-synced data.

// File: rtl/sync_bit_fifo.sv
module sync_bit_fifo #(
  parameter int          DEPTH   = 16,
  parameter logic [15:0] SYNC    = 16'h2DD4,
  parameter logic [7:0]  CMD     = 8'hCA,
  parameter logic [7:0]  CFG_RST = 8'h80,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [15:0]      cfg_data,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             rd_en,
  output logic             rd_data,
  output logic             fifo_empty,
  output logic [CNT_W-1:0] fill_level,
  output logic             fill_irq,
  output logic             overrun,
  output logic             rst_guard_off
);

  logic [3:0]       thr;
  logic             cont, fen;
  logic [15:0]      shreg;
  logic             synced;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] mem;

  wire        cfg_ok = cfg_valid && (cfg_data[15:8] == CMD);
  wire        flush  = cfg_ok && !cfg_data[1];
  wire [15:0] sh_nx  = {shreg[14:0], bit_in};
  wire        take   = bit_valid && fen && (cont || synced);
  wire        hit    = bit_valid && fen && !cont && !synced && (sh_nx == SYNC);
  wire        pop    = rd_en && (count != '0);
  wire        full   = (count == CNT_W'(DEPTH));
  wire        push   = take && (!full || pop);
  wire        lost   = take && full && !pop;

  assign rd_data    = mem[rd_ptr];
  assign fifo_empty = (count == '0);
  assign fill_level = count;
  assign fill_irq   = !fifo_empty && (count >= CNT_W'(thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr           <= CFG_RST[7:4];
      cont          <= CFG_RST[2];
      fen           <= CFG_RST[1];
      rst_guard_off <= CFG_RST[0];
    end else if (cfg_ok) begin
      thr           <= cfg_data[7:4];
      cont          <= cfg_data[2];
      fen           <= cfg_data[1];
      rst_guard_off <= cfg_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         shreg <= '0;
    else if (bit_valid) shreg <= sh_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fen || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
      synced  <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (lost) overrun <= 1'b1;
      if (hit)  synced  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= bit_in;
  end

  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> !cfg_data[3]);
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));
  a_r8_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !fifo_empty && !bit_valid && !cfg_valid |=> fill_level == $past(fill_level) - 1'b1);
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_data[15:8] == CMD && !cfg_data[1] |=> fifo_empty && !overrun);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !(cfg_valid && cfg_data[15:8] == CMD && !cfg_data[1]) |=> overrun);
  a_r9_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> fill_level == CNT_W'(DEPTH));
  a_r3_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fill_irq |-> !fifo_empty);

endmodule

// File: tb/sync_bit_fifo_bench.sv
module sync_bit_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SW = 16'h2DD4;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, bit_valid = 0, bit_in = 0, rd_en = 0;
  logic [15:0] cfg_data = '0;
  logic rd_data, fifo_empty, fill_irq, overrun, rst_guard_off;
  logic [4:0] fill_level;

  int checks = 0, errors = 0;
  bit done = 0;

  sync_bit_fifo u_sync_bit_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .bit_valid(bit_valid), .bit_in(bit_in), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .fill_level(fill_level),
    .fill_irq(fill_irq), .overrun(overrun), .rst_guard_off(rst_guard_off));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit q[$];
  int m_thr, m_cont, m_fen, m_guard, m_sync, m_ovr;
  logic [15:0] m_sh, nsh;
  bit tk, hit, acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_thr = 8; m_cont = 0; m_fen = 0; m_guard = 0;
      m_sync = 0; m_ovr = 0; m_sh = '0;
    end else begin
      nsh = {m_sh[14:0], bit_in};
      tk  = bit_valid && m_fen != 0 && (m_cont != 0 || m_sync != 0);
      hit = bit_valid && m_fen != 0 && m_cont == 0 && m_sync == 0 && nsh == SW;
      acc = cfg_valid && cfg_data[15:8] == 8'hCA;
      if (m_fen == 0 || (acc && !cfg_data[1])) begin
        q.delete(); m_ovr = 0; m_sync = 0;
      end else begin
        if (rd_en && q.size() > 0) void'(q.pop_front());
        if (tk) begin
          if (q.size() < 16) q.push_back(bit_in);
          else m_ovr = 1;
        end
        if (hit) m_sync = 1;
      end
      if (bit_valid) m_sh = nsh;
      if (acc) begin
        m_thr = cfg_data[7:4]; m_cont = cfg_data[2];
        m_fen = cfg_data[1];   m_guard = cfg_data[0];
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R8 level", fill_level, q.size());
    check("R8 empty", fifo_empty, q.size() == 0);
    check("R3 irq", fill_irq, (q.size() > 0 && q.size() >= m_thr));
    check("R9 overrun", overrun, m_ovr);
    check("R10 guard", rst_guard_off, m_guard);
    if (q.size() > 0) check("R8 head", rd_data, q[0]);
  end

  task automatic step(input logic cv, input logic [15:0] cd,
                      input logic bv, input logic b, input logic rd);
    @(negedge clk);
    cfg_valid = cv; cfg_data = cd; bit_valid = bv; bit_in = b; rd_en = rd;
    @(posedge clk); #1;
    cfg_valid = 0; bit_valid = 0; rd_en = 0;
  endtask
  task automatic send(input logic b); step(0, 16'h0, 1, b, 0); endtask
  task automatic cfg(input logic [15:0] d); step(1, d, 0, 0, 0); endtask
  task automatic rd1(); step(0, 16'h0, 0, 0, 1); endtask
  task automatic send_sync();
    for (int i = 15; i >= 0; i--) send(SW[i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    // R1
    check("R1 level", fill_level, 0);
    check("R1 empty", fifo_empty, 1);
    check("R1 irq", fill_irq, 0);
    check("R1 overrun", overrun, 0);
    check("R1 guard", rst_guard_off, 0);
    for (int i = 0; i < 3; i++) send(1);
    check("R1 fill disabled after reset", fill_level, 0);

    // R2: wrong code ignored
    cfg(16'hC586);
    for (int i = 0; i < 4; i++) send(1);
    check("R2 wrong code ignored", fill_level, 0);

    // R4 / R3: continuous, threshold 4
    cfg(16'hCA46);
    send(1); send(0); send(1);
    check("R3 irq below threshold", fill_irq, 0);
    send(1);
    check("R4 continuous level", fill_level, 4);
    check("R3 irq at threshold", fill_irq, 1);
    // R8 order
    check("R8 first bit", rd_data, 1); rd1();
    check("R8 second bit", rd_data, 0); rd1();
    check("R8 third bit", rd_data, 1); rd1();
    check("R8 fourth bit", rd_data, 1); rd1();
    check("R8 drained", fifo_empty, 1);

    // R11 / R9
    for (int i = 0; i < 16; i++) send(i[0]);
    check("R8 full level", fill_level, 16);
    step(0, 16'h0, 1, 1, 1);
    check("R11 push+pop level", fill_level, 16);
    check("R11 no overrun", overrun, 0);
    send(0);
    check("R9 overrun set", overrun, 1);
    check("R9 level held", fill_level, 16);
    rd1();
    check("R9 overrun sticky", overrun, 1);

    // R6 flush
    cfg(16'hCA44);
    check("R6 flush level", fill_level, 0);
    check("R6 flush overrun", overrun, 0);
    send(1); send(1);
    check("R6 disabled no store", fill_level, 0);

    // R5 / R10: sync mode, guard bit
    cfg(16'hCA83);
    check("R10 guard stored", rst_guard_off, 1);
    send(1); send(1); send(0);
    for (int i = 15; i >= 1; i--) send(SW[i]);
    check("R5 nothing before sync", fill_level, 0);
    send(SW[0]);
    check("R5 sync word not stored", fill_level, 0);
    send(1); send(0); send(0); send(1); send(1);
    check("R5 data after sync", fill_level, 5);
    check("R3 irq below 8", fill_irq, 0);
    for (int i = 0; i < 5; i++) rd1();
    // R7
    send_sync();
    check("R7 second sync stored", fill_level, 16);
    for (int i = 15; i >= 0; i--) begin
      check("R7 sync bits in order", rd_data, SW[i]); rd1();
    end

    // R6 re-arm
    cfg(16'hCA80); cfg(16'hCA82);
    send(1); send(0); send(1);
    check("R6 re-armed search", fill_level, 0);
    send_sync(); send(1);
    check("R6 sync after re-arm", fill_level, 1);

    // random phase, checked by the model each cycle
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      logic [15:0] d = {($urandom_range(0, 3) == 0) ? 8'h5A : 8'hCA,
                        8'($urandom) & 8'hF7};
      if (r < 4) d[1] = ($urandom_range(0, 3) != 0);
      step(r < 4, d, r >= 4 && r < 70, $urandom_range(0, 1), $urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule